// File: doc/BRIEF.md
# Feedback Divider with Single-Count Slip

This block is the feedback divider of a clock-multiplying PLL. It counts cycles of the oscillator clock and emits a one-clock feedback pulse every M cycles, where M is a programmable modulus. The phase detector compares that pulse train against the output of the reference divider.

Two control inputs let a system nudge the PLL by one oscillator period. A rising edge on the add input lengthens exactly one divide cycle to M+1 counts. A rising edge on the drop input shortens exactly one divide cycle to M-1 counts. Either one leaves the phase detector with a one-period error. The loop then removes that error by slewing, which gains or loses one output clock over time. Both inputs are asynchronous and are brought into the oscillator domain by synchronizers. The reference-divider output is synchronized in the same way, so that its rising edge can be found.

A captured request is held until the next reference rising edge. It is then applied to the divide cycle that follows. The block accepts at most one request per phase-detector cycle. A status pulse marks the end of every modified divide cycle.

Top module: `fbdiv_slip`

## Requirements
- R1: Reset is synchronous and active high. It clears the counter, the held requests and the edge history. While `rst_i` is high, `fb_o` and `slip_o` are low.
- R2: With no requests, `fb_o` is high for one clock every M clocks, so successive pulses are M clocks apart.
- R3: A rising edge on `add_i` makes exactly one divide cycle last M+1 clocks. This also holds at the largest modulus, 2^CNT_W-1.
- R4: A rising edge on `drop_i` makes exactly one divide cycle last M-1 clocks. This also holds at the smallest modulus, 3.
- R5: A captured request does not change any divide cycle until `ref_i` has risen. Without a reference rising edge, the period stays at M.
- R6: Only the first add or drop edge between two reference rising edges is accepted. Later edges in that interval are discarded.
- R7: The controls act on edges only. Holding `add_i` or `drop_i` high across several reference cycles yields a single request.
- R8: Add and drop edges that are seen in the same clock cancel each other. The modulus stays at M, and they use up that phase-detector cycle's single slot.
- R9: Requests accepted in successive phase-detector cycles accumulate. Each one contributes one clock of period change.
- R10: `slip_o` is high for one clock, together with the `fb_o` pulse that ends each modified divide cycle, and at no other time.
- R11: `mod_i` is sampled only at the terminal count. A change in the middle of a cycle leaves that cycle's length unchanged and takes effect from the next cycle. Supported moduli run from 3 to 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ref_i | input | 1 | Reference-divider output (asynchronous) |
| add_i | input | 1 | Add-one-count request (asynchronous, rising edge) |
| drop_i | input | 1 | Drop-one-count request (asynchronous, rising edge) |
| mod_i | input | CNT_W | Divide modulus M, 3 or more |
| fb_o | output | 1 | One-clock feedback pulse at each terminal count |
| slip_o | output | 1 | One-clock pulse at the end of a modified divide cycle |

## Verification
The bench builds the block with an 8-bit counter and two synchronizer stages. This makes a modulus of 255 legal, and the add case at that modulus has to reach a 256-clock period without the counter wrapping. The smallest modulus, 3, is also reachable, where a drop must give a 2-clock period. Random phases draw moduli between 3 and 32, so that many reference cycles fit in a short run. In those phases the accumulated period deviation and the number of slip pulses are compared against a model of the one-request-per-cycle and cancel rules.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
    // Kind of one-count modulus change held by the request logic
    typedef enum logic [1:0] {
        SLIP_NONE = 2'd0,
        SLIP_ADD  = 2'd1,
        SLIP_DROP = 2'd2
    } slip_e;
endpackage

// File: rtl/fbdiv_sync.sv
// Multi-stage synchronizer with rising-edge detection on each bit
module fbdiv_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] rise_o
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
        logic [WIDTH-1:0]             hist;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pipe[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        st_d.hist = st_q.pipe[LAST];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_edge
        assign rise_o[b] = st_q.pipe[LAST][b] & ~st_q.hist[b];
    end
endmodule

// File: rtl/fbdiv_req.sv
// Request capture: one slot per phase-detector cycle, armed on reference edge
module fbdiv_req
    import fbdiv_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  add_rise_i,
    input  logic  drop_rise_i,
    input  logic  ref_rise_i,
    input  logic  take_i,
    output slip_e arm_o
);
    typedef struct packed {
        slip_e req;
        slip_e arm;
        logic  taken;
    } req_st_t;

    req_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // counter loads the modified modulus at terminal count
        if (take_i) begin
            st_d.arm = SLIP_NONE;
        end
        // reference edge closes the phase-detector cycle
        if (ref_rise_i && st_d.arm == SLIP_NONE) begin
            st_d.arm   = st_q.req;
            st_d.req   = SLIP_NONE;
            st_d.taken = 1'b0;
        end
        // first edge of the new cycle claims its slot
        if ((add_rise_i || drop_rise_i) && !st_d.taken) begin
            st_d.taken = 1'b1;
            if (add_rise_i && drop_rise_i) st_d.req = SLIP_NONE;
            else if (add_rise_i)           st_d.req = SLIP_ADD;
            else                           st_d.req = SLIP_DROP;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '{req: SLIP_NONE, arm: SLIP_NONE, taken: 1'b0};
        else       st_q <= st_d;
    end

    assign arm_o = st_q.arm;
endmodule

// File: rtl/fbdiv_count.sv
// Down-counter divider; modulus sampled at terminal count only
module fbdiv_count
    import fbdiv_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [CNT_W-1:0] mod_i,
    input  slip_e            arm_i,
    output logic             tc_o,
    output logic             fb_o,
    output logic             slip_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fb;
        logic             slip;
        logic             active;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic             tc;
    logic [CNT_W-1:0] load;

    assign tc = (st_q.cnt == '0);

    // reload value is one less than the length of the next cycle
    always_comb begin
        if (arm_i == SLIP_ADD)       load = mod_i;
        else if (arm_i == SLIP_DROP) load = mod_i - TWO;
        else                         load = mod_i - ONE;
    end

    always_comb begin
        st_d      = st_q;
        st_d.fb   = tc;
        st_d.slip = tc & st_q.active;
        if (tc) begin
            st_d.cnt    = load;
            st_d.active = (arm_i != SLIP_NONE);
        end else begin
            st_d.cnt = st_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign tc_o   = tc;
    assign fb_o   = st_q.fb;
    assign slip_o = st_q.slip;
endmodule

// File: rtl/fbdiv_slip.sv
module fbdiv_slip
    import fbdiv_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             ref_i,
    input  logic             add_i,
    input  logic             drop_i,
    input  logic [CNT_W-1:0] mod_i,
    output logic             fb_o,
    output logic             slip_o
);
    localparam int N_CTL = 3;

    logic [N_CTL-1:0] rise;
    logic             ref_rise;
    slip_e            arm;
    logic             tc;

    fbdiv_sync #(.WIDTH(N_CTL), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i ({ref_i, drop_i, add_i}),
        .rise_o  (rise)
    );

    assign ref_rise = rise[2];

    fbdiv_req u_req (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .add_rise_i  (rise[0]),
        .drop_rise_i (rise[1]),
        .ref_rise_i  (ref_rise),
        .take_i      (tc),
        .arm_o       (arm)
    );

    fbdiv_count #(.CNT_W(CNT_W)) u_count (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .mod_i  (mod_i),
        .arm_i  (arm),
        .tc_o   (tc),
        .fb_o   (fb_o),
        .slip_o (slip_o)
    );
endmodule

// File: rtl/fbdiv_slip_chk.sv
module fbdiv_slip_chk (
    input logic       clk,
    input logic       rst,
    input logic       fb,
    input logic       slip,
    input logic       ref_rise,
    input logic [1:0] arm,
    input logic       tc
);
    // R1: outputs quiet after a reset clock
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!fb && !slip));

    // R2: feedback pulse lasts one clock
    p_fb_single_r2: assert property (@(posedge clk) disable iff (rst)
        fb |=> !fb);

    // R10: status pulse only alongside a feedback pulse
    p_slip_on_fb_r10: assert property (@(posedge clk) disable iff (rst)
        slip |-> fb);

    // R5: a request becomes armed only after a reference edge
    p_arm_after_ref_r5: assert property (@(posedge clk) disable iff (rst)
        (arm != 2'd0 && $past(arm) == 2'd0) |-> $past(ref_rise));

    // R5: armed request waits for the terminal count
    p_arm_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (arm != 2'd0 && !tc) |=> (arm == $past(arm)));

    // R3: armed request is used by exactly one divide cycle
    p_arm_consumed_r3: assert property (@(posedge clk) disable iff (rst)
        (arm != 2'd0 && tc && !ref_rise) |=> (arm == 2'd0));
endmodule

bind fbdiv_slip fbdiv_slip_chk u_chk (
    .clk      (clk_i),
    .rst      (rst_i),
    .fb       (fb_o),
    .slip     (slip_o),
    .ref_rise (ref_rise),
    .arm      (arm),
    .tc       (tc)
);

// File: tb/fbdiv_slip_test.sv
`timescale 1ns/1ps
module fbdiv_slip_test;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ref_s = 1'b0;
    logic             add_s = 1'b0;
    logic             drop_s = 1'b0;
    logic [CNT_W-1:0] mod_s = CNT_W'(10);
    logic             fb;
    logic             slip;

    int total = 0;
    int bad   = 0;

    // monitor statistics
    int cyc = 0;
    int last = -1;
    int skip = 2;
    int m_ref = 10;
    int dev_sum = 0;
    int slip_cnt = 0;
    int slip_bad = 0;
    int mn = 1 << 30;
    int mx = 0;

    always #2.5 clk = ~clk;

    fbdiv_slip #(.CNT_W(CNT_W), .SYNC_STAGES(2)) uut (
        .clk_i  (clk),
        .rst_i  (rst),
        .ref_i  (ref_s),
        .add_i  (add_s),
        .drop_i (drop_s),
        .mod_i  (mod_s),
        .fb_o   (fb),
        .slip_o (slip)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst) begin
            last = -1;
        end else if (fb) begin
            if (last >= 0) begin
                if (skip > 0) begin
                    skip = skip - 1;
                end else begin
                    dev_sum = dev_sum + (cyc - last - m_ref);
                    if (cyc - last < mn) mn = cyc - last;
                    if (cyc - last > mx) mx = cyc - last;
                    if (((cyc - last) != m_ref) != slip) slip_bad = slip_bad + 1;
                end
            end
            last = cyc;
            if (slip) slip_cnt = slip_cnt + 1;
        end else if (slip) begin
            slip_bad = slip_bad + 1;
        end
    end

    function automatic int slip_delta(input int kind);
        // kind 0 add, 1 drop, 2 both
        if (kind == 0) return 1;
        if (kind == 1) return -1;
        return 0;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_stats();
        dev_sum = 0; slip_cnt = 0; slip_bad = 0; mn = 1 << 30; mx = 0;
    endtask

    task automatic set_m(input int m);
        mod_s = CNT_W'(m);
        m_ref = m;
        skip  = 2;
    endtask

    task automatic settle();
        tick(4 * m_ref + 20);
    endtask

    task automatic pulse(input int kind);
        if (kind != 1) add_s = 1'b1;
        if (kind != 0) drop_s = 1'b1;
        tick(3);
        add_s = 1'b0; drop_s = 1'b0;
        tick(3);
    endtask

    task automatic ref_pulse();
        ref_s = 1'b1; tick(2); ref_s = 1'b0; tick(2);
    endtask

    initial begin
        int n;
        int exp_dev;
        int exp_slips;
        void'($urandom(32'h0005_eed1));
        tick(4);
        check("R1 fb in reset", int'(fb), 0);
        check("R1 slip in reset", int'(slip), 0);
        rst = 1'b0;

        // R2: plain division
        set_m(10); settle(); clear_stats(); tick(60);
        check("R2 min period", mn, 10);
        check("R2 max period", mx, 10);
        set_m(7); settle(); clear_stats(); tick(50);
        check("R2 period M=7", mx, 7);

        // R3: add
        set_m(10); settle(); clear_stats();
        pulse(0); ref_pulse(); settle();
        check("R3 add deviation", dev_sum, 1);
        check("R3 add longest", mx, 11);
        check("R10 add slip pulses", slip_cnt, 1);
        check("R10 slip alignment", slip_bad, 0);

        // R4: drop
        clear_stats(); pulse(1); ref_pulse(); settle();
        check("R4 drop deviation", dev_sum, -1);
        check("R4 drop shortest", mn, 9);

        // R5: held until the reference edge
        clear_stats(); pulse(0); tick(60);
        check("R5 no ref deviation", dev_sum, 0);
        check("R5 no ref slips", slip_cnt, 0);
        ref_pulse(); settle();
        check("R5 after ref deviation", dev_sum, 1);

        // R6: one request per phase-detector cycle
        clear_stats(); pulse(0); pulse(0); pulse(1); ref_pulse(); settle();
        check("R6 extra edges ignored", dev_sum, 1);
        check("R6 slip count", slip_cnt, 1);

        // R7: level held high
        clear_stats(); add_s = 1'b1; tick(3);
        ref_pulse(); settle(); ref_pulse(); settle(); ref_pulse(); settle();
        add_s = 1'b0; tick(4);
        check("R7 level no repeat", dev_sum, 1);

        // R8: simultaneous add and drop cancel and use the slot
        clear_stats(); pulse(2); pulse(0); ref_pulse(); settle();
        check("R8 cancel deviation", dev_sum, 0);
        check("R8 cancel slips", slip_cnt, 0);

        // R9: accumulation over successive cycles
        clear_stats();
        for (int i = 0; i < 3; i++) begin
            pulse(0); ref_pulse(); tick(2 * m_ref + 4);
        end
        settle();
        check("R9 accumulated", dev_sum, 3);
        check("R9 slip count", slip_cnt, 3);

        // R4 boundary: smallest modulus
        set_m(3); settle(); clear_stats(); pulse(1); ref_pulse(); settle();
        check("R4 M=3 shortest", mn, 2);
        check("R4 M=3 deviation", dev_sum, -1);

        // R3 boundary: largest modulus
        set_m(255); settle(); clear_stats(); pulse(0); ref_pulse(); settle();
        check("R3 M=255 longest", mx, 256);
        check("R3 M=255 deviation", dev_sum, 1);

        // R11: mid-cycle modulus change
        set_m(10); settle();
        while (!fb) tick(1);
        tick(3);
        mod_s = CNT_W'(20);
        n = 3;
        do begin tick(1); n++; end while (!fb);
        check("R11 current cycle keeps M", n, 10);
        n = 0;
        do begin tick(1); n++; end while (!fb);
        check("R11 next cycle new M", n, 20);
        set_m(20); settle();

        // random phases against the acceptance model (R6, R8, R9, R10)
        for (int ph = 0; ph < 6; ph++) begin
            set_m(3 + int'($urandom % 30)); settle(); clear_stats();
            exp_dev = 0; exp_slips = 0;
            for (int w = 0; w < 8; w++) begin
                int k;
                k = int'($urandom % 4);
                for (int e = 0; e < k; e++) begin
                    int kind;
                    kind = int'($urandom % 3);
                    tick(int'($urandom % 5));
                    pulse(kind);
                    if (e == 0) begin
                        exp_dev += slip_delta(kind);
                        if (kind != 2) exp_slips++;
                    end
                end
                ref_pulse();
                tick(2 * m_ref + 4);
            end
            settle();
            check("R9 random deviation", dev_sum, exp_dev);
            check("R10 random slip count", slip_cnt, exp_slips);
            check("R10 random slip alignment", slip_bad, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(150000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule